// File: doc/BRIEF.md
# Transmit Staging Buffer with Batched Commit

This block holds outgoing serial bytes in a 1024-byte circular RAM. Software fills a memory-mapped window with any number of bytes, placed relative to the current write pointer. None of those bytes reaches the transmitter until software writes a byte count to the control register. That write makes the whole batch available at once.

The transmitter side takes the oldest committed byte over a ready/valid handshake, one byte per accepted transfer. The control register returns the write pointer, the fill count and a sticky overflow flag together in one word.

The block raises a space-available signal when the free room is at least a programmed trigger size. It raises an empty signal when no committed byte is left.

Top module: `txbuf_top`

## Requirements
- R1: After reset the fill count, write pointer and overflow flag are zero, `tx_valid_o` is 0, `tx_empty_o` and `space_avail_o` are 1, and the trigger code reads back as 5.
- R2: A register write in the window 0x400-0x7FF stores each enabled byte lane L (`reg_be_i[L]`, data `reg_wdata_i[8L+7:8L]`) at RAM index (write pointer + `reg_addr_i[9:2]`*4 + L) mod 1024. Disabled lanes are left alone, and a window write never makes a byte visible to the transmitter.
- R3: A read of the control register at 0x804 returns the write pointer in bits [9:0], the fill count in bits [25:16] and the overflow flag in bit 31, with all other bits zero. The read data appears on `reg_rdata_o` the cycle after the request and is zero when no read is requested.
- R4: A write of N (bits [9:0]) to 0x804 advances both the write pointer and the fill count by N.
- R5: `tx_valid_o` is high whenever the fill count is nonzero. `tx_data_o` is the oldest committed byte and holds while it is not accepted. Each cycle with `tx_valid_o` and `tx_ready_i` both high removes exactly one byte, in commit order.
- R6: A commit of N in the same cycle as an accepted byte leaves the fill count at count + N - 1.
- R7: The fill count never exceeds 1023. A commit larger than (1023 - count) is cut down to (1023 - count) and sets the sticky overflow flag. A control write with bit 31 set clears the flag; a clamping commit in the same write keeps it set.
- R8: The trigger code is config register 0x808 bits [18:16], written when `reg_be_i[2]` is set. It is read back at the same position. `space_avail_o` is 1 exactly when (1023 - count) >= 4 << code.
- R9: `tx_empty_o` is 1 exactly when the fill count is zero.
- R10: The write pointer and read position wrap modulo 1024, and window writes that run past index 1023 continue at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte address of the word accessed |
| reg_be_i | input | 4 | Byte-lane enables for writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the request |
| tx_valid_o | output | 1 | A committed byte is offered |
| tx_ready_i | input | 1 | Transmitter accepts the offered byte |
| tx_data_o | output | 8 | Oldest committed byte |
| space_avail_o | output | 1 | Free room is at or above the trigger size |
| tx_empty_o | output | 1 | No committed byte remains |

## Verification
A commit and a byte drain both change the pointer and count registers at the clock edge that accepts them. `tx_valid_o`, `tx_data_o`, `space_avail_o` and `tx_empty_o` follow in the same cycle after that edge, while a register read shows up on `reg_rdata_o` exactly one edge after the request. The bench drives every input on the falling edge, so each access spans a single rising edge. It samples all outputs on the next falling edge, so each read result and each status flag is compared against the reference model exactly one edge after its cause. The one drain issued in the same cycle as a commit is checked at the falling edge before that shared rising edge, and again through a control read afterwards.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int unsigned REG_AW = 12;
  localparam logic [REG_AW-1:0] CTRL_ADDR = 12'h804;
  localparam logic [REG_AW-1:0] CONF_ADDR = 12'h808;
  localparam logic [1:0]        WIN_TAG   = 2'b01;   // addr[11:10] of 0x400-0x7FF
  localparam int unsigned CNT_LSB = 16;
  localparam int unsigned LVL_LSB = 16;
  localparam int unsigned ERR_BIT = 31;
endpackage

// File: rtl/txbuf_ram.sv
module txbuf_ram #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [3:0]    be_i,
  input  logic [AW-1:0] wbase_i,
  input  logic [AW-3:0] woff_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] lane_idx [4];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane_idx[g] = wbase_i + {woff_i, 2'(g)};
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < 4; l++) begin
      if (we_i && be_i[l]) mem_q[lane_idx[l]] <= wdata_i[8*l +: 8];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl #(
  parameter int unsigned AW    = 10,
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [AW-1:0]    commit_n_i,
  input  logic             err_clr_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             tx_ready_i,
  output logic [AW-1:0]    wptr_o,
  output logic [AW-1:0]    rptr_o,
  output logic [AW-1:0]    count_o,
  output logic             err_o,
  output logic             tx_valid_o,
  output logic             space_o,
  output logic             empty_o
);
  localparam logic [AW-1:0] CAP = '1;

  logic [AW-1:0] wptr_q, rptr_q, count_q;
  logic          err_q;
  logic [AW-1:0] free_w, amt_w, pop_w;
  logic          clamp_w, take_w;
  logic [AW:0]   thr_w;

  assign free_w  = CAP - count_q;
  assign clamp_w = commit_i && (commit_n_i > free_w);
  assign amt_w   = !commit_i ? '0 : (clamp_w ? free_w : commit_n_i);
  assign take_w  = (count_q != '0) && tx_ready_i;
  assign pop_w   = {{(AW-1){1'b0}}, take_w};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      err_q   <= 1'b0;
    end else begin
      wptr_q  <= wptr_q + amt_w;
      rptr_q  <= rptr_q + pop_w;
      count_q <= count_q + amt_w - pop_w;
      if (clamp_w)        err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  // trigger size 4 << code
  assign thr_w = {{(AW-2){1'b0}}, 3'b100} << lvl_i;

  assign wptr_o     = wptr_q;
  assign rptr_o     = rptr_q;
  assign count_o    = count_q;
  assign err_o      = err_q;
  assign tx_valid_o = (count_q != '0);
  assign empty_o    = (count_q == '0);
  assign space_o    = ({1'b0, free_w} >= thr_w);
endmodule

// File: rtl/txbuf_regif.sv
module txbuf_regif
  import txbuf_pkg::*;
#(
  parameter int unsigned       AW      = 10,
  parameter int unsigned       LVL_W   = 3,
  parameter logic [LVL_W-1:0]  LVL_RST = 3'd5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  logic [AW-1:0]     wptr_i,
  input  logic [AW-1:0]     count_i,
  input  logic              err_i,
  output logic [31:0]       rdata_o,
  output logic              win_we_o,
  output logic              commit_o,
  output logic [AW-1:0]     commit_n_o,
  output logic              err_clr_o,
  output logic [LVL_W-1:0]  lvl_o
);
  logic             hit_win, hit_ctrl, hit_conf, wr;
  logic [LVL_W-1:0] lvl_q;
  logic [31:0]      rdata_q, ctrl_word, conf_word;

  assign hit_win  = (addr_i[REG_AW-1:REG_AW-2] == WIN_TAG);
  assign hit_ctrl = (addr_i == CTRL_ADDR);
  assign hit_conf = (addr_i == CONF_ADDR);
  assign wr       = req_i && we_i;

  assign win_we_o   = wr && hit_win;
  assign commit_o   = wr && hit_ctrl;
  assign commit_n_o = wdata_i[AW-1:0];
  assign err_clr_o  = wr && hit_ctrl && wdata_i[ERR_BIT];

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[AW-1:0]          = wptr_i;
    ctrl_word[CNT_LSB +: AW]   = count_i;
    ctrl_word[ERR_BIT]         = err_i;
    conf_word                  = '0;
    conf_word[LVL_LSB +: LVL_W] = lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= LVL_RST;
      rdata_q <= '0;
    end else begin
      if (wr && hit_conf && be_i[2]) lvl_q <= wdata_i[LVL_LSB +: LVL_W];
      if (req_i && !we_i) begin
        if (hit_ctrl)      rdata_q <= ctrl_word;
        else if (hit_conf) rdata_q <= conf_word;
        else               rdata_q <= '0;
      end else begin
        rdata_q <= '0;
      end
    end
  end

  assign rdata_o = rdata_q;
  assign lvl_o   = lvl_q;
endmodule

// File: rtl/txbuf_top.sv
module txbuf_top
  import txbuf_pkg::*;
#(
  parameter int unsigned      AW      = 10,
  parameter int unsigned      LVL_W   = 3,
  parameter logic [LVL_W-1:0] LVL_RST = 3'd5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [3:0]        reg_be_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              space_avail_o,
  output logic              tx_empty_o
);
  logic             win_we, commit, err_clr, err;
  logic [AW-1:0]    commit_n, wptr, rptr, count;
  logic [LVL_W-1:0] lvl;

  txbuf_regif #(.AW(AW), .LVL_W(LVL_W), .LVL_RST(LVL_RST)) u_regif (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .be_i(reg_be_i), .wdata_i(reg_wdata_i),
    .wptr_i(wptr), .count_i(count), .err_i(err),
    .rdata_o(reg_rdata_o), .win_we_o(win_we), .commit_o(commit),
    .commit_n_o(commit_n), .err_clr_o(err_clr), .lvl_o(lvl)
  );

  txbuf_ctrl #(.AW(AW), .LVL_W(LVL_W)) u_ctrl (
    .clk_i, .rst_ni,
    .commit_i(commit), .commit_n_i(commit_n), .err_clr_i(err_clr),
    .lvl_i(lvl), .tx_ready_i,
    .wptr_o(wptr), .rptr_o(rptr), .count_o(count), .err_o(err),
    .tx_valid_o, .space_o(space_avail_o), .empty_o(tx_empty_o)
  );

  txbuf_ram #(.AW(AW)) u_ram (
    .clk_i, .we_i(win_we), .be_i(reg_be_i),
    .wbase_i(wptr), .woff_i(reg_addr_i[AW-1:2]), .wdata_i(reg_wdata_i),
    .raddr_i(rptr), .rdata_o(tx_data_o)
  );
endmodule

// File: rtl/txbuf_top_chk.sv
module txbuf_top_chk
  import txbuf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [31:0]       reg_rdata_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [7:0]        tx_data_o,
  input logic              space_avail_o,
  input logic              tx_empty_o
);
  AST_VALID_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o != tx_empty_o); // R9

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !(reg_req_i && reg_we_i)
    |=> tx_valid_o && $stable(tx_data_o)); // R5

  AST_NO_COMMIT_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o && !(reg_req_i && reg_we_i && reg_addr_i == CTRL_ADDR)
    |=> tx_empty_o); // R2

  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_req_i |=> reg_rdata_o == 32'h0); // R3

  AST_SPACE_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> space_avail_o); // R8
endmodule

bind txbuf_top txbuf_top_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_req_i(reg_req_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o), .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
  .space_avail_o(space_avail_o), .tx_empty_o(tx_empty_o)
);

// File: tb/txbuf_top_tb_top.sv
module txbuf_top_tb_top;
  localparam logic [11:0] CTRL = 12'h804;
  localparam logic [11:0] CONF = 12'h808;
  localparam logic [11:0] WIN  = 12'h400;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0, tx_ready_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [3:0]  reg_be_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        tx_valid_o, space_avail_o, tx_empty_o;
  logic [7:0]  tx_data_o;

  int checks = 0, errors = 0;

  // reference model
  logic [7:0] mem_m [1024];
  int wptr_m = 0, rptr_m = 0, count_m = 0, lvl_m = 5;
  bit err_m = 0;

  always #10 clk = ~clk;

  txbuf_top dut_i (
    .clk_i(clk), .rst_ni, .reg_req_i, .reg_we_i, .reg_addr_i, .reg_be_i,
    .reg_wdata_i, .reg_rdata_o, .tx_valid_o, .tx_ready_i, .tx_data_o,
    .space_avail_o, .tx_empty_o
  );

  function automatic bit space_m();
    return (1023 - count_m) >= (4 << lvl_m);
  endfunction

  function automatic logic [31:0] ctrl_m();
    logic [31:0] w = '0;
    w[9:0] = 10'(wptr_m); w[25:16] = 10'(count_m); w[31] = err_m;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_commit(input logic [31:0] d, input bit drained);
    int n = int'(d[9:0]);
    int fr = 1023 - count_m;
    int a = (n > fr) ? fr : n;
    if (n > fr) err_m = 1;
    else if (d[31]) err_m = 0;
    wptr_m = (wptr_m + a) & 1023;
    count_m = count_m + a - (drained ? 1 : 0);
    if (drained) rptr_m = (rptr_m + 1) & 1023;
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_req_i = 1; reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d; reg_be_i = be;
    @(negedge clk);
    reg_req_i = 0; reg_we_i = 0;
    if (a[11:10] == 2'b01) begin
      for (int l = 0; l < 4; l++)
        if (be[l]) mem_m[(wptr_m + int'(a[9:2]) * 4 + l) & 1023] = d[8*l +: 8];
    end else if (a == CTRL) model_commit(d, 0);
    else if (a == CONF && be[2]) lvl_m = int'(d[18:16]);
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req_i = 1; reg_we_i = 0; reg_addr_i = a;
    @(negedge clk);
    reg_req_i = 0;
    d = reg_rdata_o;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] d;
    reg_read(CTRL, d);
    chk(d === ctrl_m(), tag, d, ctrl_m());
    chk(tx_empty_o === (count_m == 0), "R9 empty flag", 32'(tx_empty_o), 32'(count_m == 0));
    chk(space_avail_o === space_m(), "R8 space flag", 32'(space_avail_o), 32'(space_m()));
  endtask

  task automatic drain(input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk(tx_valid_o === 1'b1, "R5 valid", 32'(tx_valid_o), 32'd1);
      chk(tx_data_o === mem_m[rptr_m], "R5 R10 data order", 32'(tx_data_o), 32'(mem_m[rptr_m]));
      tx_ready_i = 1;
      @(negedge clk);
      rptr_m = (rptr_m + 1) & 1023;
      count_m--;
    end
    tx_ready_i = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w0;
    void'($urandom(32'h1d5e_7a01));
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    @(negedge clk);
    chk(tx_valid_o === 0, "R1 valid", 32'(tx_valid_o), 0);
    chk(tx_empty_o === 1 && space_avail_o === 1, "R1 flags", {tx_empty_o, space_avail_o}, 2'b11);
    reg_read(CTRL, d); chk(d === 32'h0, "R1 R3 ctrl", d, 0);
    reg_read(CONF, d); chk(d === 32'h0005_0000, "R1 R8 conf", d, 32'h0005_0000);

    // R2 fill whole window; nothing offered without commit
    for (int w = 0; w < 256; w++) reg_write(WIN + 12'(w * 4), $urandom, 4'hf);
    @(negedge clk);
    chk(tx_valid_o === 0, "R2 uncommitted hidden", 32'(tx_valid_o), 0);

    // R3 R4 commit 3 then drain
    reg_write(CTRL, 32'd3, 4'hf);
    check_state("R3 R4 commit");
    drain(3);
    check_state("R9 drained");

    // R2 single lane at wptr=3, offset 0 lane1 -> index 4
    reg_write(WIN, 32'h0000_A500, 4'b0010);
    chk(mem_m[4] === 8'hA5, "R2 lane model", 32'(mem_m[4]), 32'hA5);
    reg_write(CTRL, 32'd2, 4'hf);
    drain(2);

    // R6 simultaneous commit and drain
    reg_write(CTRL, 32'd4, 4'hf);
    @(negedge clk);
    chk(tx_data_o === mem_m[rptr_m], "R6 data", 32'(tx_data_o), 32'(mem_m[rptr_m]));
    tx_ready_i = 1; reg_req_i = 1; reg_we_i = 1; reg_addr_i = CTRL; reg_wdata_i = 32'd5; reg_be_i = 4'hf;
    @(negedge clk);
    tx_ready_i = 0; reg_req_i = 0; reg_we_i = 0;
    model_commit(32'd5, 1);
    chk(count_m == 8, "R6 model", 32'(count_m), 8);
    check_state("R6 commit plus drain");
    drain(count_m);

    // R8 thresholds
    reg_write(CTRL, 32'd895, 4'hf);
    @(negedge clk);
    chk(space_avail_o === 1, "R8 free 128 code5", 32'(space_avail_o), 1);
    reg_write(CTRL, 32'd1, 4'hf);
    @(negedge clk);
    chk(space_avail_o === 0, "R8 free 127 code5", 32'(space_avail_o), 0);
    reg_write(CONF, 32'h0007_0000, 4'b0100);
    reg_read(CONF, d); chk(d === 32'h0007_0000, "R8 code readback", d, 32'h0007_0000);
    drain(384);
    chk(space_avail_o === 0, "R8 free 511 code7", 32'(space_avail_o), 0);
    drain(1);
    chk(space_avail_o === 1, "R8 free 512 code7", 32'(space_avail_o), 1);
    reg_write(CONF, 32'h0001_0000, 4'b1011);
    reg_read(CONF, d); chk(d === 32'h0007_0000, "R8 lane2 gate", d, 32'h0007_0000);
    drain(count_m);
    reg_write(CONF, 32'h0005_0000, 4'b0100);

    // random phase
    for (int it = 0; it < 80; it++) begin
      int nw = $urandom_range(0, 3);
      for (int k = 0; k < nw; k++)
        reg_write(WIN + 12'($urandom_range(0, 15) * 4), $urandom, 4'($urandom_range(0, 15)));
      if (it % 7 == 0) reg_write(CONF, {13'd0, 3'($urandom_range(0, 7)), 16'd0}, 4'hf);
      reg_write(CTRL, {($urandom_range(0, 3) == 0), 21'd0, 10'($urandom_range(0, 60))}, 4'hf);
      check_state("R4 R10 random commit");
      drain($urandom_range(0, (count_m > 40) ? 40 : count_m));
    end
    drain(count_m);

    // R7 clamp and sticky error, R10 wrap
    reg_write(CTRL, 32'h8000_0000, 4'hf);
    reg_read(CTRL, d); w0 = int'(d[9:0]);
    reg_write(CTRL, 32'd1000, 4'hf);
    reg_write(CTRL, 32'd100, 4'hf);
    reg_read(CTRL, d);
    chk(d[25:16] === 10'd1023 && d[31] === 1'b1, "R7 clamp", d, ctrl_m());
    chk(d[9:0] === 10'((w0 + 1023) & 1023), "R10 wptr wrap", 32'(d[9:0]), 32'((w0 + 1023) & 1023));
    reg_write(CTRL, 32'd0, 4'hf);
    check_state("R7 sticky");
    reg_write(CTRL, 32'h8000_0000, 4'hf);
    check_state("R7 clear");
    drain(count_m);
    check_state("R9 final empty");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule